// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

The block sits on the controller side of an SDRAM interface. It takes read requests aimed at a row that is already open, turns each into a READ command on the chip's command, address and bank-select pins, and picks the returned words off the data bus in the right cycle. Each request names a bank, a starting column, the number of words wanted and whether the row is to be closed automatically when the burst ends. Returned words leave as a tagged stream that carries the data, its column and a last-word marker.

CAS latency (1 to 3 clocks) and the device burst length (1, 2, 4, 8 words or a full page) are static configuration inputs. They may only change while no burst is in flight. The request side is a valid/ready handshake. A request is taken in any cycle where both are high, and the requester must hold all request fields stable while valid is high and ready is low. Ready drops after a request is taken and rises again at the earliest cycle at which the next READ can follow without a gap on the data bus. This allows seamless chaining of bursts, and a shorter request truncates the device burst with the next READ. The read stream has no ready input, because an SDRAM cannot be stalled once a READ is issued. The consumer must accept one word in every cycle that rd_valid is high.

Top module: `sdr_rd_seq`

## Requirements
- R1: A request taken in cycle c (req_valid and req_ready both high) appears in cycle c+1 as a READ, encoded {cs_n,ras_n,cas_n,we_n} = 0101. sdr_ba carries the bank, sdr_addr[COL_W-1:0] carries the starting column, sdr_addr[AP_BIT] carries the auto-precharge flag, and every other address bit is 0.
- R2: In every cycle not preceded by a taken request, and during and after reset, the pins show NOP (0111) with sdr_addr and sdr_ba at 0. After reset, req_ready is 1 and rd_valid is 0.
- R3: The effective length L of a request is req_len, limited to the burst capacity. cfg_bl codes 0..3 give a capacity of 1, 2, 4 or 8 words, and codes 4..7 give a full page of 2^COL_W words. A req_len of 0 or above the capacity means the full capacity.
- R4: After a request of effective length L is taken in cycle c, req_ready is low in cycles c+1 to c+L-1 and high in cycle c+L.
- R5: With cfg_cl = CL (1..3) and a READ on the pins in cycle n, rd_valid first rises in cycle n+1+CL. rd_data then holds the value that sdr_dq_i had at the clock edge that starts that cycle.
- R6: A request yields exactly L rd_valid cycles in a row, one per word, and rd_last is high only on the L-th word.
- R7: For fixed bursts, rd_col counts up from the start column and wraps inside the block of burst-length columns aligned to that length.
- R8: For full-page bursts, rd_col counts up and wraps from 2^COL_W-1 to 0.
- R9: When each request is presented as soon as req_ready allows, the words of consecutive requests arrive with no idle cycle between them. This holds when a new READ truncates a device burst.
- R10: Words the device returns beyond a request's L words are never marked valid. This covers words past a truncation point and the rest of a fixed burst that no new READ follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cl | input | CL_W (2) | CAS latency, 1..MAX_CL |
| cfg_bl | input | 3 | Burst length code: 0..3 give 2^code words, 4..7 give a full page |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_bank | input | BANK_W (2) | Target bank |
| req_col | input | COL_W (8) | Starting column |
| req_len | input | COL_W+1 (9) | Words wanted, 0 = capacity |
| req_ap | input | 1 | Close the row after the burst |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_addr | output | ADDR_W (11) | Address pins |
| sdr_ba | output | BANK_W (2) | Bank-select pins |
| sdr_dq_i | input | DW (32) | Data from the device |
| rd_valid | output | 1 | Returned word valid |
| rd_data | output | DW (32) | Returned word |
| rd_col | output | COL_W (8) | Column of the returned word |
| rd_last | output | 1 | Last wanted word of a request |

## Verification
The bench builds the block with COL_W = 6 and DW = 16, and keeps MAX_CL = 3. The 64-column page lets a full-page burst run through its wrap to column 0 within a short run. All three CAS latencies are selected in turn. Every burst code from 2 words up to a full page is used, so wraps inside aligned blocks, truncation by chained READs, and the unwanted tail of an uninterrupted fixed burst are all exercised.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  // Command pin pattern {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_READ = 4'b0101,
    CMD_NOP  = 4'b0111
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_rd_issue.sv
module sdr_rd_issue
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10,
  parameter int LEN_W  = COL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_bl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_ap,
  output sdr_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic              go_o,
  output logic [COL_W-1:0]  go_col_o,
  output logic [LEN_W-1:0]  go_len_o
);
  sdr_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BANK_W-1:0] ba_q;
  logic [LEN_W-1:0]  gap_q, len_q, cap, eff_len;
  logic              hs;

  // Burst capacity and effective word count
  assign cap     = cfg_bl[2] ? (LEN_W'(1) << COL_W) : (LEN_W'(1) << cfg_bl[1:0]);
  assign eff_len = (req_len == '0 || req_len > cap) ? cap : req_len;

  // Ready only once the gap-free issue point has been reached
  assign req_ready = (gap_q == '0);
  assign hs        = req_valid && req_ready;

  always_comb begin
    addr_d              = '0;
    addr_d[COL_W-1:0]   = req_col;
    addr_d[AP_BIT]      = req_ap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      gap_q  <= '0;
      len_q  <= '0;
    end else if (hs) begin
      cmd_q  <= CMD_READ;
      addr_q <= addr_d;
      ba_q   <= req_bank;
      gap_q  <= eff_len - LEN_W'(1);
      len_q  <= eff_len;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      if (gap_q != '0) gap_q <= gap_q - LEN_W'(1);
    end
  end

  assign cmd_o    = cmd_q;
  assign addr_o   = addr_q;
  assign ba_o     = ba_q;
  assign go_o     = (cmd_q == CMD_READ);
  assign go_col_o = addr_q[COL_W-1:0];
  assign go_len_o = len_q;

  assert_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_o == CMD_READ && ba_o == $past(req_bank)
      && addr_o[AP_BIT] == $past(req_ap) && addr_o[COL_W-1:0] == $past(req_col)));

  assert_idle_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (cmd_o == CMD_NOP && addr_o == '0));

  assert_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && eff_len != LEN_W'(1)) |=> !req_ready);
endmodule

// File: rtl/sdr_rd_beat.sv
module sdr_rd_beat #(
  parameter int COL_W = 8,
  parameter int LEN_W = COL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_bl,
  input  logic             go,
  input  logic [COL_W-1:0] go_col,
  input  logic [LEN_W-1:0] go_len,
  output logic             beat_v,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last
);
  // Follows the device's internal column counter: one beat per cycle,
  // starting in the cycle after the device registers the READ.
  logic             act_q;
  logic [COL_W-1:0] col_q, col_nxt, mask;
  logic [LEN_W-1:0] left_q;

  assign mask    = cfg_bl[2] ? '1 : ~({COL_W{1'b1}} << cfg_bl[1:0]);
  assign col_nxt = (col_q & ~mask) | ((col_q + COL_W'(1)) & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      col_q  <= '0;
      left_q <= '0;
    end else if (go) begin
      act_q  <= 1'b1;
      col_q  <= go_col;
      left_q <= go_len - LEN_W'(1);
    end else if (act_q) begin
      if (left_q == '0) begin
        act_q <= 1'b0;
      end else begin
        left_q <= left_q - LEN_W'(1);
        col_q  <= col_nxt;
      end
    end
  end

  assign beat_v    = act_q;
  assign beat_col  = col_q;
  assign beat_last = act_q && (left_q == '0);

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !go && !cfg_bl[2]) |=>
      (!act_q || ((col_q & ~mask) == ($past(col_q) & ~mask))));
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int COL_W  = 8,
  parameter int DW     = 32,
  parameter int MAX_CL = 3,
  parameter int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CL_W-1:0]  cfg_cl,
  input  logic             beat_v,
  input  logic [COL_W-1:0] beat_col,
  input  logic             beat_last,
  input  logic [DW-1:0]    dq_i,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [COL_W-1:0] rd_col,
  output logic             rd_last
);
  // Stage 0 is the live beat; stage k is that beat delayed k cycles.
  // Tap CL-1 marks the cycle whose closing edge holds the word (MAX_CL >= 2).
  logic             st_v    [MAX_CL];
  logic [COL_W-1:0] st_col  [MAX_CL];
  logic             st_last [MAX_CL];
  logic             tap_v, tap_last;
  logic [COL_W-1:0] tap_col;

  assign st_v[0]    = beat_v;
  assign st_col[0]  = beat_col;
  assign st_last[0] = beat_last;

  for (genvar k = 1; k < MAX_CL; k++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_v[k]    <= 1'b0;
        st_col[k]  <= '0;
        st_last[k] <= 1'b0;
      end else begin
        st_v[k]    <= st_v[k-1];
        st_col[k]  <= st_col[k-1];
        st_last[k] <= st_last[k-1];
      end
    end
  end

  always_comb begin
    tap_v    = st_v[0];
    tap_col  = st_col[0];
    tap_last = st_last[0];
    for (int k = 1; k < MAX_CL; k++) begin
      if (cfg_cl == CL_W'(k + 1)) begin
        tap_v    = st_v[k];
        tap_col  = st_col[k];
        tap_last = st_last[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_col   <= '0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= tap_v;
      rd_last  <= tap_v && tap_last;
      if (tap_v) begin
        rd_data <= dq_i;
        rd_col  <= tap_col;
      end
    end
  end

  assert_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> rd_valid);

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);
endmodule

// File: rtl/sdr_rd_seq.sv
module sdr_rd_seq
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10,
  parameter int DW     = 32,
  parameter int MAX_CL = 3,
  localparam int LEN_W = COL_W + 1,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CL_W-1:0]   cfg_cl,
  input  logic [2:0]        cfg_bl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_ap,
  output logic              sdr_cs_n,
  output logic              sdr_ras_n,
  output logic              sdr_cas_n,
  output logic              sdr_we_n,
  output logic [ADDR_W-1:0] sdr_addr,
  output logic [BANK_W-1:0] sdr_ba,
  input  logic [DW-1:0]     sdr_dq_i,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [COL_W-1:0]  rd_col,
  output logic              rd_last
);
  sdr_cmd_e         cmd;
  logic             go, beat_v, beat_last;
  logic [COL_W-1:0] go_col, beat_col;
  logic [LEN_W-1:0] go_len;

  sdr_rd_issue #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .LEN_W(LEN_W)
  ) i_issue (
    .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_col(req_col), .req_len(req_len), .req_ap(req_ap),
    .cmd_o(cmd), .addr_o(sdr_addr), .ba_o(sdr_ba),
    .go_o(go), .go_col_o(go_col), .go_len_o(go_len)
  );

  assign {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = cmd;

  sdr_rd_beat #(.COL_W(COL_W), .LEN_W(LEN_W)) i_beat (
    .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl),
    .go(go), .go_col(go_col), .go_len(go_len),
    .beat_v(beat_v), .beat_col(beat_col), .beat_last(beat_last)
  );

  sdr_rd_capture #(.COL_W(COL_W), .DW(DW), .MAX_CL(MAX_CL), .CL_W(CL_W)) i_capture (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl),
    .beat_v(beat_v), .beat_col(beat_col), .beat_last(beat_last),
    .dq_i(sdr_dq_i),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_col(rd_col), .rd_last(rd_last)
  );

  assert_cl_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cl != '0 && cfg_cl <= CL_W'(MAX_CL)));
endmodule

// File: tb/test_sdr_rd_seq.sv
`timescale 1ns/1ps
module test_sdr_rd_seq;
  localparam int BANK_W = 2;
  localparam int COL_W  = 6;
  localparam int ADDR_W = 11;
  localparam int AP_BIT = 10;
  localparam int DW     = 16;
  localparam int MAX_CL = 3;
  localparam int LEN_W  = COL_W + 1;
  localparam int PAGE   = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_cl = 2'd1;
  logic [2:0] cfg_bl = 3'd0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic req_ap = 1'b0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [ADDR_W-1:0] sdr_addr;
  logic [BANK_W-1:0] sdr_ba;
  logic [DW-1:0] sdr_dq;
  logic rd_valid, rd_last;
  logic [DW-1:0] rd_data;
  logic [COL_W-1:0] rd_col;

  always #2.5 clk = ~clk;

  sdr_rd_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
               .DW(DW), .MAX_CL(MAX_CL)) i_sdr_rd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_col(req_col), .req_len(req_len), .req_ap(req_ap),
    .sdr_cs_n(cs_n), .sdr_ras_n(ras_n), .sdr_cas_n(cas_n), .sdr_we_n(we_n),
    .sdr_addr(sdr_addr), .sdr_ba(sdr_ba), .sdr_dq_i(sdr_dq),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_col(rd_col), .rd_last(rd_last)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c);
    return DW'({b, c}) ^ DW'(16'h5A00);
  endfunction

  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] c, input logic [2:0] bl);
    int sz;
    sz = bl[2] ? PAGE : (1 << bl[1:0]);
    return COL_W'((c / sz) * sz + ((c % sz) + 1) % sz);
  endfunction

  // ---------------- device model: follows SDRAM read timing ----------------
  logic m_act = 1'b0;
  logic [BANK_W-1:0] m_bank = '0;
  logic [COL_W-1:0] m_col = '0;
  int m_left = 0;
  logic d1_v = 1'b0, d2_v = 1'b0;
  logic [DW-1:0] d1_w = '0, d2_w = '0;
  logic [DW-1:0] m_w;
  logic tap_v;
  logic [DW-1:0] tap_w;

  assign m_w   = word_of(m_bank, m_col);
  assign tap_v = (cfg_cl == 2'd1) ? m_act : (cfg_cl == 2'd2) ? d1_v : d2_v;
  assign tap_w = (cfg_cl == 2'd1) ? m_w   : (cfg_cl == 2'd2) ? d1_w : d2_w;
  assign sdr_dq = tap_v ? tap_w : 'z;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act <= 1'b0;
    end else if ({cs_n, ras_n, cas_n, we_n} == 4'b0101) begin
      m_act  <= 1'b1;
      m_bank <= sdr_ba;
      m_col  <= sdr_addr[COL_W-1:0];
      m_left <= (cfg_bl[2] ? PAGE : (1 << cfg_bl[1:0])) - 1;
    end else if (m_act) begin
      if (!cfg_bl[2] && m_left == 0) m_act <= 1'b0;
      else begin
        m_left <= m_left - 1;
        m_col  <= next_col(m_col, cfg_bl);
      end
    end
    d1_v <= m_act; d1_w <= m_w;
    d2_v <= d1_v;  d2_w <= d1_w;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [DW-1:0]    data;
    logic [COL_W-1:0] col;
    bit               last;
    string            tag;
  } item_t;
  item_t exp_q[$];

  int cmd_cyc = 0, first_cyc = 0, gaps = 0, extra = 0;
  bit started = 0;

  task automatic send(input int b, input int c, input int len, input bit ap);
    int cap, l;
    logic [COL_W-1:0] col;
    logic [ADDR_W-1:0] ea;
    req_bank = BANK_W'(b); req_col = COL_W'(c); req_len = LEN_W'(len); req_ap = ap;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cmd_cyc = cyc;
    ea = '0; ea[COL_W-1:0] = COL_W'(c); ea[AP_BIT] = ap;
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0101, "R1 read pins",
        {cs_n, ras_n, cas_n, we_n}, 4'b0101);
    chk(sdr_ba == BANK_W'(b), "R1 bank", sdr_ba, b);
    chk(sdr_addr == ea, "R1 address", sdr_addr, ea);
    cap = cfg_bl[2] ? PAGE : (1 << cfg_bl[1:0]);
    l = (len == 0 || len > cap) ? cap : len;
    col = COL_W'(c);
    for (int k = 0; k < l; k++) begin
      exp_q.push_back('{word_of(BANK_W'(b), col), col, (k == l - 1),
                        cfg_bl[2] ? "R8" : "R7"});
      col = next_col(col, cfg_bl);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    started = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          extra++;
          chk(0, "R10 unwanted word marked valid", rd_col, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          if (!started) first_cyc = cyc;
          started = 1;
          chk(rd_data == it.data, "R5 data", rd_data, it.data);
          chk(rd_col == it.col, it.tag, rd_col, it.col);
          chk(rd_last == it.last, "R6 last", rd_last, it.last);
        end
      end else if (started && exp_q.size() != 0) begin
        gaps++;
      end
    end
  end

  // R2: every cycle without a preceding handshake shows NOP
  bit hs_q = 0;
  always @(posedge clk) hs_q <= rst_n && req_valid && req_ready;
  always @(negedge clk) begin
    if (!hs_q) begin
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && sdr_addr == '0 && sdr_ba == '0,
          "R2 nop", {cs_n, ras_n, cas_n, we_n, sdr_addr}, {4'b0111, 11'h0});
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, 100000);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R2 reset ready", req_ready, 1);
    chk(rd_valid == 1'b0, "R2 reset rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);

    // R5/R6/R7: single 4-word bursts at each latency, wrap 5,6,7,4
    for (int cl = 1; cl <= 3; cl++) begin
      cfg_cl = 2'(cl); cfg_bl = 3'd2;
      @(negedge clk);
      send(1, 5, 4, 1'b1);
      drain();
      chk(first_cyc - cmd_cyc == 1 + cl, "R5 latency", first_cyc - cmd_cyc, 1 + cl);
    end

    // R10/R3: 3 words of an 8-word burst, rest of the burst must stay invalid
    cfg_cl = 2'd3; cfg_bl = 3'd3;
    extra = 0;
    send(2, 13, 3, 1'b0);
    drain();
    chk(extra == 0, "R10 tail of fixed burst", extra, 0);

    // R4: ready spacing
    cfg_cl = 2'd2;
    send(0, 0, 4, 1'b0);
    cnt = 0;
    while (!req_ready) begin cnt++; @(negedge clk); end
    chk(cnt == 3, "R4 ready low cycles", cnt, 3);
    drain();
    send(3, 40, 1, 1'b0);
    chk(req_ready == 1'b1, "R4 ready after length 1", req_ready, 1);
    drain();

    // R3: clipping to capacity and length 0
    cfg_bl = 3'd1;
    send(3, 9, 5, 1'b0);
    send(1, 20, 0, 1'b0);
    drain();

    // R9: chained requests with truncation, CL 1 and CL 3
    for (int cl = 1; cl <= 3; cl += 2) begin
      cfg_cl = 2'(cl); cfg_bl = 3'd3;
      gaps = 0; extra = 0;
      send(0, 2, 3, 1'b0);
      send(1, 7, 8, 1'b0);
      send(2, 0, 1, 1'b1);
      send(3, 4, 2, 1'b0);
      drain();
      chk(gaps == 0, "R9 gap-free chain", gaps, 0);
      chk(extra == 0, "R10 truncated words", extra, 0);
    end

    // R8: full page, wraps 63 -> 0; then truncation of full-page bursts
    cfg_cl = 2'd2; cfg_bl = 3'd7;
    send(1, 60, 0, 1'b0);
    drain();
    gaps = 0; extra = 0;
    send(0, 62, 5, 1'b0);
    send(2, 3, 2, 1'b0);
    drain();
    chk(gaps == 0, "R9 full-page truncation gap", gaps, 0);
    chk(extra == 0, "R10 full-page truncation", extra, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule